// File: doc/BRIEF.md
# Write-Through Valid/Invalid Snooping Cache Controller

This block manages a small direct-mapped write-through cache that sits on a shared snooping bus. Each line holds one presence bit, a tag and a single data word. A line that is not valid counts as absent, so there is no separate empty state. The local processor issues one read or write at a time. The controller either answers a read from the line store or runs one bus transaction. Every write goes to the bus.

The bus uses an atomic handshake. The controller raises a request and holds the operation and address until it sees a grant. It then waits for a done pulse. A read fills the line on done, and a write completes on done. Writes never allocate a line. The controller also watches bus transactions made by other agents. A snooped write to an address whose line is present drops that line. Each bus transaction carries a requester identifier, so the controller ignores traffic that it issued itself.

Top module: `wt_vi_snoop_ctrl`

## Requirements
- R1: After reset every line is absent, and `cpu_busy`, `cpu_rvalid` and `bus_req` are low.
- R2: A read to an absent line, or to a line holding another tag, issues exactly one bus read (`bus_op` = 2'b01) for that address. When `bus_done` arrives the line becomes present with the returned word. In the same cycle `cpu_rvalid` pulses with that word on `cpu_rdata`.
- R3: A read to a present line with a matching tag issues no bus transaction. `cpu_rvalid` pulses in the cycle after the request, with the stored word.
- R4: Every write, hit or miss, issues exactly one bus write (`bus_op` = 2'b10) carrying the request address and data.
- R5: A write to an absent line does not allocate it, so a later read of that address issues a bus read.
- R6: A write to a present line with a matching tag also replaces the stored word. A later read is answered locally with the new word.
- R7: A snooped write (`snoop_op` = 2'b10) from a requester whose ID differs from `MY_ID`, to an address whose line is present with that tag, makes the line absent on the next clock edge.
- R8: A snooped read (`snoop_op` = 2'b01) has no effect on the line store. Neither does a snooped write that carries `MY_ID` or addresses a different tag.
- R9: `cpu_busy` is high from the cycle after a missing read or any write is accepted until the cycle after `bus_done`. While `bus_req` is high and no grant has arrived, the request and its address stay unchanged.
- R10: The line index is the low `IDX_W` address bits, and the tag is the remaining upper bits. Two addresses with the same index but different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_req | input | 1 | Processor request strobe, taken when `cpu_busy` is low |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Processor word address |
| cpu_wdata | input | DATA_W | Processor write data |
| cpu_busy | output | 1 | A bus transaction is in progress |
| cpu_rvalid | output | 1 | One-cycle read return strobe |
| cpu_rdata | output | DATA_W | Read return data |
| bus_req | output | 1 | Bus transaction request |
| bus_op | output | 2 | 2'b01 read, 2'b10 write, 2'b00 none |
| bus_addr | output | ADDR_W | Bus transaction address |
| bus_wdata | output | DATA_W | Bus write data |
| bus_src_id | output | ID_W | Requester ID of this controller |
| bus_gnt | input | 1 | Grant for the pending request |
| bus_done | input | 1 | Completion of the granted transaction |
| bus_rdata | input | DATA_W | Read data, valid with `bus_done` |
| snoop_valid | input | 1 | A bus transaction is visible this cycle |
| snoop_op | input | 2 | Snooped operation code, same encoding as `bus_op` |
| snoop_addr | input | ADDR_W | Snooped address |
| snoop_id | input | ID_W | Requester ID of the snooped transaction |

## Verification
The assertions assume the bus keeps its handshake. `bus_gnt` arrives only while `bus_req` is high, and `bus_done` arrives only after a grant. They also assume the processor sends requests only while `cpu_busy` is low. Snooped transactions from other agents are assumed never to coincide with this controller's own transaction, because the bus is atomic. The bench drives a responder that grants and completes after random delays and only after it sees a request. Processor operations and snoops are issued one at a time, only once the controller is idle.

// File: rtl/wt_vi_pkg.sv
package wt_vi_pkg;

  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_RD   = 2'b01,
    OP_WR   = 2'b10
  } bus_op_e;

  typedef enum logic [1:0] {
    FSM_IDLE = 2'b00,
    FSM_REQ  = 2'b01,
    FSM_WAIT = 2'b10
  } fsm_e;

endpackage

// File: rtl/wt_vi_line_store.sv
module wt_vi_line_store #(
  parameter int IDX_W  = 4,
  parameter int TAG_W  = 8,
  parameter int DATA_W = 32,
  localparam int LINES = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  lk_idx,
  input  logic [TAG_W-1:0]  lk_tag,
  output logic              lk_hit,
  output logic [DATA_W-1:0] lk_data,
  input  logic [IDX_W-1:0]  sn_idx,
  input  logic [TAG_W-1:0]  sn_tag,
  output logic              sn_match,
  input  logic              kill_en,
  input  logic              fill_en,
  input  logic              upd_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data,
  input  logic [DATA_W-1:0] upd_data,
  output logic [LINES-1:0]  valid_vec
);

  logic [LINES-1:0]  valid_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [DATA_W-1:0] data_q [LINES];

  // Per-line state; a snoop kill outranks a fill on the same line.
  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic sel_lk;
    logic sel_sn;
    assign sel_lk = (lk_idx == IDX_W'(i));
    assign sel_sn = (sn_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        valid_q[i] <= 1'b0;
      end else if (kill_en && sel_sn) begin
        valid_q[i] <= 1'b0;
      end else if (fill_en && sel_lk) begin
        valid_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_en && sel_lk) begin
        tag_q[i]  <= fill_tag;
        data_q[i] <= fill_data;
      end else if (upd_en && sel_lk) begin
        data_q[i] <= upd_data;
      end
    end
  end

  assign lk_hit    = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
  assign lk_data   = data_q[lk_idx];
  assign sn_match  = valid_q[sn_idx] && (tag_q[sn_idx] == sn_tag);
  assign valid_vec = valid_q;

endmodule

// File: rtl/wt_vi_snoop_filter.sv
module wt_vi_snoop_filter #(
  parameter int ID_W  = 2,
  parameter int MY_ID = 1
) (
  input  logic            snoop_valid,
  input  logic [1:0]      snoop_op,
  input  logic [ID_W-1:0] snoop_id,
  input  logic            line_match,
  output logic            kill
);
  import wt_vi_pkg::*;

  logic foreign;
  logic is_write;

  assign foreign  = (snoop_id != ID_W'(MY_ID));
  assign is_write = (bus_op_e'(snoop_op) == OP_WR);
  assign kill     = snoop_valid && is_write && foreign && line_match;

endmodule

// File: rtl/wt_vi_req_fsm.sv
module wt_vi_req_fsm #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  input  logic              lk_hit,
  input  logic [DATA_W-1:0] lk_data,
  output logic [ADDR_W-1:0] lk_addr,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic              accept,
  output logic              bus_fin,
  output logic              fill_en,
  output logic              upd_en
);
  import wt_vi_pkg::*;

  fsm_e              state_q, state_d;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_wdata_q;
  logic              pend_we_q;
  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;
  logic              local_hit;

  assign accept    = (state_q == FSM_IDLE) && cpu_req;
  assign local_hit = accept && !cpu_we && lk_hit;
  assign lk_addr   = (state_q == FSM_IDLE) ? cpu_addr : pend_addr_q;
  assign bus_fin   = (state_q == FSM_WAIT) && bus_done;
  assign fill_en   = bus_fin && !pend_we_q;
  assign upd_en    = bus_fin && pend_we_q && lk_hit;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      FSM_IDLE: if (accept && !local_hit) state_d = FSM_REQ;
      FSM_REQ:  if (bus_gnt)              state_d = FSM_WAIT;
      FSM_WAIT: if (bus_done)             state_d = FSM_IDLE;
      default:                            state_d = FSM_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= FSM_IDLE;
      pend_addr_q  <= '0;
      pend_wdata_q <= '0;
      pend_we_q    <= 1'b0;
      rvalid_q     <= 1'b0;
      rdata_q      <= '0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= 1'b0;
      if (accept) begin
        pend_addr_q  <= cpu_addr;
        pend_wdata_q <= cpu_wdata;
        pend_we_q    <= cpu_we;
      end
      if (local_hit) begin
        rvalid_q <= 1'b1;
        rdata_q  <= lk_data;
      end else if (fill_en) begin
        rvalid_q <= 1'b1;
        rdata_q  <= bus_rdata;
      end
    end
  end

  assign cpu_busy   = (state_q != FSM_IDLE);
  assign cpu_rvalid = rvalid_q;
  assign cpu_rdata  = rdata_q;
  assign bus_req    = (state_q == FSM_REQ);
  assign bus_op     = bus_req ? (pend_we_q ? OP_WR : OP_RD) : OP_NONE;
  assign bus_addr   = pend_addr_q;
  assign bus_wdata  = pend_wdata_q;

endmodule

// File: rtl/wt_vi_snoop_ctrl.sv
module wt_vi_snoop_ctrl #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_busy,
  output logic              cpu_rvalid,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  output logic [1:0]        bus_op,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  output logic [ID_W-1:0]   bus_src_id,
  input  logic              bus_gnt,
  input  logic              bus_done,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              snoop_valid,
  input  logic [1:0]        snoop_op,
  input  logic [ADDR_W-1:0] snoop_addr,
  input  logic [ID_W-1:0]   snoop_id
);

  localparam int LINES = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  function automatic logic [IDX_W-1:0] line_idx(input logic [ADDR_W-1:0] a);
    return a[IDX_W-1:0];
  endfunction

  function automatic logic [TAG_W-1:0] line_tag(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:IDX_W];
  endfunction

  // Named internal events, also observed by the bound checker.
  logic [ADDR_W-1:0] lk_addr;
  logic [IDX_W-1:0]  line_sel;
  logic [IDX_W-1:0]  snoop_idx;
  logic              lookup_hit;
  logic [DATA_W-1:0] lk_data;
  logic              snoop_match;
  logic              snoop_kill;
  logic              accept;
  logic              bus_fin;
  logic              fill_en;
  logic              upd_en;
  logic [LINES-1:0]  valid_vec;

  assign line_sel   = line_idx(lk_addr);
  assign snoop_idx  = line_idx(snoop_addr);
  assign bus_src_id = ID_W'(MY_ID);

  wt_vi_req_fsm #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) fsm_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_req    (cpu_req),
    .cpu_we     (cpu_we),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_busy   (cpu_busy),
    .cpu_rvalid (cpu_rvalid),
    .cpu_rdata  (cpu_rdata),
    .lk_hit     (lookup_hit),
    .lk_data    (lk_data),
    .lk_addr    (lk_addr),
    .bus_req    (bus_req),
    .bus_op     (bus_op),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_gnt    (bus_gnt),
    .bus_done   (bus_done),
    .bus_rdata  (bus_rdata),
    .accept     (accept),
    .bus_fin    (bus_fin),
    .fill_en    (fill_en),
    .upd_en     (upd_en)
  );

  wt_vi_line_store #(
    .IDX_W  (IDX_W),
    .TAG_W  (TAG_W),
    .DATA_W (DATA_W)
  ) store_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .lk_idx    (line_sel),
    .lk_tag    (line_tag(lk_addr)),
    .lk_hit    (lookup_hit),
    .lk_data   (lk_data),
    .sn_idx    (snoop_idx),
    .sn_tag    (line_tag(snoop_addr)),
    .sn_match  (snoop_match),
    .kill_en   (snoop_kill),
    .fill_en   (fill_en),
    .upd_en    (upd_en),
    .fill_tag  (line_tag(lk_addr)),
    .fill_data (bus_rdata),
    .upd_data  (bus_wdata),
    .valid_vec (valid_vec)
  );

  wt_vi_snoop_filter #(
    .ID_W  (ID_W),
    .MY_ID (MY_ID)
  ) filt_i (
    .snoop_valid (snoop_valid),
    .snoop_op    (snoop_op),
    .snoop_id    (snoop_id),
    .line_match  (snoop_match),
    .kill        (snoop_kill)
  );

endmodule

// File: rtl/wt_vi_snoop_ctrl_chk.sv
module wt_vi_snoop_ctrl_chk #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 4,
  parameter int ID_W   = 2,
  parameter int MY_ID  = 1,
  localparam int LINES = 1 << IDX_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_we,
  input logic              cpu_busy,
  input logic              cpu_rvalid,
  input logic              bus_req,
  input logic [1:0]        bus_op,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              snoop_valid,
  input logic [ID_W-1:0]   snoop_id,
  input logic              accept,
  input logic              lookup_hit,
  input logic              snoop_kill,
  input logic [IDX_W-1:0]  snoop_idx,
  input logic              fill_en,
  input logic [IDX_W-1:0]  line_sel,
  input logic              bus_fin,
  input logic [LINES-1:0]  valid_vec
);

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !bus_req);

  p_fill_sets_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_vec[$past(line_sel)] && cpu_rvalid);

  p_hit_no_bus_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !cpu_we && lookup_hit |=> !bus_req && cpu_rvalid && !cpu_busy);

  p_write_goes_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && cpu_we |=> bus_req && bus_op == 2'b10);

  p_no_alloc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fill_en |=> $countones(valid_vec) <= $countones($past(valid_vec)));

  p_snoop_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_kill |=> !valid_vec[$past(snoop_idx)]);

  p_own_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    snoop_valid && snoop_id == ID_W'(MY_ID) |-> !snoop_kill);

  p_req_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_gnt |=> bus_req && $stable(bus_addr) && $stable(bus_op));

  p_busy_covers_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req |-> cpu_busy);

  p_fin_frees_r9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_fin |=> !cpu_busy);

endmodule

bind wt_vi_snoop_ctrl wt_vi_snoop_ctrl_chk #(
  .ADDR_W (ADDR_W),
  .IDX_W  (IDX_W),
  .ID_W   (ID_W),
  .MY_ID  (MY_ID)
) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .cpu_we      (cpu_we),
  .cpu_busy    (cpu_busy),
  .cpu_rvalid  (cpu_rvalid),
  .bus_req     (bus_req),
  .bus_op      (bus_op),
  .bus_addr    (bus_addr),
  .bus_gnt     (bus_gnt),
  .snoop_valid (snoop_valid),
  .snoop_id    (snoop_id),
  .accept      (accept),
  .lookup_hit  (lookup_hit),
  .snoop_kill  (snoop_kill),
  .snoop_idx   (snoop_idx),
  .fill_en     (fill_en),
  .line_sel    (line_sel),
  .bus_fin     (bus_fin),
  .valid_vec   (valid_vec)
);

// File: tb/wt_vi_snoop_ctrl_tb_top.sv
module wt_vi_snoop_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int IDX_W  = 4;
  localparam int ID_W   = 2;
  localparam int MY_ID  = 1;
  localparam int LINES  = 1 << IDX_W;
  localparam int MEM_N  = 1 << ADDR_W;
  localparam int WATCHDOG = 150000;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cpu_req = 1'b0;
  logic              cpu_we = 1'b0;
  logic [ADDR_W-1:0] cpu_addr = '0;
  logic [DATA_W-1:0] cpu_wdata = '0;
  logic              cpu_busy;
  logic              cpu_rvalid;
  logic [DATA_W-1:0] cpu_rdata;
  logic              bus_req;
  logic [1:0]        bus_op;
  logic [ADDR_W-1:0] bus_addr;
  logic [DATA_W-1:0] bus_wdata;
  logic [ID_W-1:0]   bus_src_id;
  logic              bus_gnt = 1'b0;
  logic              bus_done = 1'b0;
  logic [DATA_W-1:0] bus_rdata = '0;
  logic              snoop_valid = 1'b0;
  logic [1:0]        snoop_op = 2'b00;
  logic [ADDR_W-1:0] snoop_addr = '0;
  logic [ID_W-1:0]   snoop_id = '0;

  wt_vi_snoop_ctrl #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .IDX_W (IDX_W),
    .ID_W (ID_W), .MY_ID (MY_ID)
  ) dut_i (
    .clk (clk), .rst_n (rst_n),
    .cpu_req (cpu_req), .cpu_we (cpu_we), .cpu_addr (cpu_addr),
    .cpu_wdata (cpu_wdata), .cpu_busy (cpu_busy), .cpu_rvalid (cpu_rvalid),
    .cpu_rdata (cpu_rdata), .bus_req (bus_req), .bus_op (bus_op),
    .bus_addr (bus_addr), .bus_wdata (bus_wdata), .bus_src_id (bus_src_id),
    .bus_gnt (bus_gnt), .bus_done (bus_done), .bus_rdata (bus_rdata),
    .snoop_valid (snoop_valid), .snoop_op (snoop_op),
    .snoop_addr (snoop_addr), .snoop_id (snoop_id)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int rd_grants = 0;
  int wr_grants = 0;
  logic [ADDR_W-1:0] last_addr;
  logic [DATA_W-1:0] last_wdata;

  // Reference model of lines and of memory.
  bit                mv [LINES];
  logic [ADDR_W-1:0] mt [LINES];
  logic [DATA_W-1:0] md [LINES];
  logic [DATA_W-1:0] mem [MEM_N];

  function automatic int slot_of(input logic [ADDR_W-1:0] a);
    return int'(a) % LINES;
  endfunction

  function automatic logic [ADDR_W-1:0] high_of(input logic [ADDR_W-1:0] a);
    return ADDR_W'(int'(a) / LINES);
  endfunction

  function automatic bit model_hit(input logic [ADDR_W-1:0] a);
    return mv[slot_of(a)] && (mt[slot_of(a)] == high_of(a));
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=expired expected=done");
    finish_run();
  end

  // Bus responder: grant and complete after random delays.
  initial begin : responder
    logic [1:0]        op;
    logic [ADDR_W-1:0] a;
    logic [DATA_W-1:0] w;
    forever begin
      @(negedge clk);
      if (bus_req && !bus_gnt) begin
        op = bus_op; a = bus_addr; w = bus_wdata;
        repeat ($urandom_range(0, 2)) @(negedge clk);
        bus_gnt = 1'b1;
        if (op == 2'b01) rd_grants++;
        if (op == 2'b10) wr_grants++;
        last_addr = a; last_wdata = w;
        @(negedge clk);
        bus_gnt = 1'b0;
        repeat ($urandom_range(0, 3)) @(negedge clk);
        if (op == 2'b01) bus_rdata = mem[a];
        else mem[a] = w;
        bus_done = 1'b1;
        @(negedge clk);
        bus_done = 1'b0;
        bus_rdata = $urandom;
      end
    end
  end

  task automatic wait_idle();
    int guard = 0;
    while (cpu_busy && guard < 200) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic cpu_read(input logic [ADDR_W-1:0] a, input string tag);
    bit hit = model_hit(a);
    int r0 = rd_grants;
    logic [DATA_W-1:0] exp = hit ? md[slot_of(a)] : mem[a];
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = a;
    @(negedge clk);
    cpu_req = 1'b0;
    wait_idle();
    if (hit) begin
      check(cpu_rvalid == 1'b1, "R3", {tag, " hit rvalid"}, cpu_rvalid, 1);
      check(cpu_rdata == exp, "R3", {tag, " hit data"}, cpu_rdata, exp);
      check(rd_grants == r0, "R3", {tag, " hit bus reads"}, rd_grants - r0, 0);
    end else begin
      check(cpu_rvalid == 1'b1, "R2", {tag, " miss rvalid"}, cpu_rvalid, 1);
      check(cpu_rdata == exp, "R2", {tag, " miss data"}, cpu_rdata, exp);
      check(rd_grants == r0 + 1, "R2", {tag, " miss bus reads"}, rd_grants - r0, 1);
      check(last_addr == a, "R2", {tag, " miss bus addr"}, last_addr, a);
    end
    mv[slot_of(a)] = 1'b1;
    mt[slot_of(a)] = high_of(a);
    md[slot_of(a)] = exp;
  endtask

  task automatic cpu_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    bit hit = model_hit(a);
    int w0 = wr_grants;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_req = 1'b0;
    check(cpu_busy == 1'b1, "R9", "busy after write accept", cpu_busy, 1);
    wait_idle();
    check(wr_grants == w0 + 1, "R4", "one bus write", wr_grants - w0, 1);
    check(last_addr == a, "R4", "bus write addr", last_addr, a);
    check(last_wdata == d, "R4", "bus write data", last_wdata, d);
    if (hit) md[slot_of(a)] = d;
  endtask

  task automatic snoop(input logic [1:0] op, input logic [ADDR_W-1:0] a,
                       input int id, input logic [DATA_W-1:0] d);
    @(negedge clk);
    snoop_valid = 1'b1; snoop_op = op; snoop_addr = a; snoop_id = ID_W'(id);
    if (op == 2'b10 && id != MY_ID) mem[a] = d;
    if (op == 2'b10 && id != MY_ID && model_hit(a)) mv[slot_of(a)] = 1'b0;
    @(negedge clk);
    snoop_valid = 1'b0;
  endtask

  initial begin : stim
    void'($urandom(32'd4242));
    for (int i = 0; i < MEM_N; i++) mem[i] = (i * 32'h9E3779B1) ^ 32'h5A5A0000;
    for (int i = 0; i < LINES; i++) begin mv[i] = 1'b0; mt[i] = '0; md[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(cpu_busy == 1'b0, "R1", "busy after reset", cpu_busy, 0);
    check(bus_req == 1'b0, "R1", "bus_req after reset", bus_req, 0);
    check(cpu_rvalid == 1'b0, "R1", "rvalid after reset", cpu_rvalid, 0);
    check(bus_src_id == ID_W'(MY_ID), "R1", "requester id", bus_src_id, MY_ID);
    cpu_read(12'h000, "R1 first read");
    // R2 then R3
    cpu_read(12'h013, "R2 cold");
    cpu_read(12'h013, "R3 warm");
    // R6: write hit updates local copy
    cpu_write(12'h013, 32'hCAFE0013);
    cpu_read(12'h013, "R6 after write hit");
    check(cpu_rdata == 32'hCAFE0013, "R6", "new data on hit", cpu_rdata, 32'hCAFE0013);
    // R5: write miss does not allocate
    cpu_write(12'h0A5, 32'hBEEF00A5);
    check(!model_hit(12'h0A5), "R5", "model line absent", 0, 0);
    cpu_read(12'h0A5, "R5 read after write miss");
    check(cpu_rdata == 32'hBEEF00A5, "R5", "fetched written data", cpu_rdata, 32'hBEEF00A5);
    // R7: foreign snooped write drops the line
    snoop(2'b10, 12'h013, 2, 32'h77770013);
    cpu_read(12'h013, "R7 after foreign write");
    check(cpu_rdata == 32'h77770013, "R7", "refetched data", cpu_rdata, 32'h77770013);
    // R8: own-id write, snooped read, other-tag write leave line intact
    snoop(2'b10, 12'h0A5, MY_ID, 32'h11110000);
    snoop(2'b01, 12'h0A5, 3, 32'h0);
    snoop(2'b10, 12'h1A5, 0, 32'h22220000);
    cpu_read(12'h0A5, "R8 line kept");
    check(cpu_rdata == 32'hBEEF00A5, "R8", "kept data", cpu_rdata, 32'hBEEF00A5);
    // R10: same index, other tag evicts
    cpu_read(12'h1A5, "R10 evict");
    cpu_read(12'h0A5, "R10 evicted");
    // Constrained random mix
    for (int n = 0; n < 400; n++) begin
      int sel = $urandom_range(0, 99);
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom_range(0, 3) * LINES + $urandom_range(0, LINES - 1));
      if (sel < 45) cpu_read(a, "rand");
      else if (sel < 75) cpu_write(a, $urandom);
      else snoop(($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01, a,
                 $urandom_range(0, 3), $urandom);
    end
    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule